// File: doc/BRIEF.md
# Multi-bus 4-bit processor core

This block is a small 4-bit processor core. It steps through a program of 16-bit instruction words held in a 32-line instruction store. Its data lives in a file of sixteen 4-bit registers. It has no accumulator. Each result lands on one of three held buses: a primary bus, a secondary bus, and an excess bus that carries the upper half of a product. Store instructions copy a bus, or a nibble taken from the instruction word itself, back into the register file.

Every instruction takes one clock. The core covers register-to-bus loads, bus-to-register stores, add, subtract, multiply, four bitwise operations, a primary/secondary bus swap, an unconditional jump, jumps on a compare flag, and halt. A testbench or loader fills the instruction store through a write port, normally while reset is held. A debug port reads any register at any time. The arithmetic and compare logic is a separate unit inside the core.

Top module: `nib4_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears the program counter, all sixteen registers, the three buses and the four compare flags to zero, and `halted` reads 0 after that edge.
- R2: READ (opcode 1) copies register[arg1] onto the primary bus when word bit 4 is 0, and onto the secondary bus when word bit 4 is 1. The other bus keeps its value.
- R3: WRITE (opcode 2) stores into register[arg1] a source chosen by word bits [5:4]: 00 primary bus, 01 secondary bus, 10 excess bus, 11 the immediate nibble in word bits [3:0].
- R4: The opcodes ADD 3, SUB 4, BOR 6, BAND 7, BXOR 8 and BNOT 9 read A = register[arg1] and B = register[arg2]. They place A+B mod 16, A-B mod 16, A|B, A&B, A^B or ~A on the primary bus. The excess bus is left unchanged.
- R5: MUL (opcode 5) places the low nibble of A*B on the primary bus and the high nibble on the excess bus.
- R6: Every instruction with opcode 3 to 9 updates four flags. Index 0 is A>B, index 1 is A<B, index 2 is A==B, and index 3 means the new primary-bus value is zero. No other instruction changes the flags.
- R7: JMP (opcode A) loads the program counter with word bits [11:7]. JMPIF (B) does the same only when the flag selected by word bits [6:5] is 1. JMPIFNOT (C) does the same only when that flag is 0. A jump that is not taken advances the program counter by one.
- R8: SWAPBUS (opcode D) exchanges the primary and secondary bus contents in one cycle.
- R9: HALT (opcode E) sets `halted`. From then until reset, the program counter, buses, flags and registers hold their values.
- R10: All other instructions advance the program counter by one, wrapping from 31 to 0. Opcodes 0 and F change nothing else.
- R11: The word layout is opcode [15:12], arg1 [11:8] and arg2 [7:4]. The instruction store is written at `rom_addr` when `rom_we` is high at a clock edge. `dbg_data` shows register[`dbg_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_we | input | 1 | Instruction store write enable |
| rom_addr | input | 5 | Instruction store write line |
| rom_data | input | 16 | Instruction word to store |
| halted | output | 1 | High once HALT has executed, until reset |
| dbg_addr | input | 4 | Debug register select |
| dbg_data | output | 4 | Contents of the selected register |

## Verification
A multiply drives the primary bus, the excess bus and all four flags in the same cycle. A miswired enable could drop any one of them. Each operation vector is therefore followed by two stores, one from the primary bus and one from the excess bus, and then by four JMPIFNOT-guarded immediate stores that turn each flag into a register value. The bench checks all six registers against its own arithmetic model, including products such as 15*15 that fill both nibbles. A second overlap is the program counter wrap and a taken conditional jump on the line after it; a program that jumps to line 30 and runs on through line 31 tests both.

// File: rtl/nib4_pkg.sv
package nib4_pkg;
  localparam int DATA_W = 4;
  localparam int REG_AW = 4;
  localparam int PC_W   = 5;
  localparam int WORD_W = 16;
  localparam int FLAG_N = 4;

  localparam int FLAG_GT   = 0;
  localparam int FLAG_LT   = 1;
  localparam int FLAG_EQ   = 2;
  localparam int FLAG_ZERO = 3;

  typedef enum logic [3:0] {
    OP_NON    = 4'h0, OP_READ  = 4'h1, OP_WRITE = 4'h2, OP_ADD   = 4'h3,
    OP_SUB    = 4'h4, OP_MUL   = 4'h5, OP_BOR   = 4'h6, OP_BAND  = 4'h7,
    OP_BXOR   = 4'h8, OP_BNOT  = 4'h9, OP_JMP   = 4'hA, OP_JMPIF = 4'hB,
    OP_JMPIFN = 4'hC, OP_SWAP  = 4'hD, OP_HALT  = 4'hE, OP_SPARE = 4'hF
  } opcode_e;

  function automatic logic is_alu_op(opcode_e op);
    return (op >= OP_ADD) && (op <= OP_BNOT);
  endfunction

  function automatic logic is_pc_redirect(opcode_e op);
    return (op == OP_JMP) || (op == OP_JMPIF) || (op == OP_JMPIFN) || (op == OP_HALT);
  endfunction
endpackage

// File: rtl/nib4_rom.sv
module nib4_rom
  import nib4_pkg::*;
#(
  parameter int AW = PC_W,
  parameter int W  = WORD_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/nib4_regfile.sv
module nib4_regfile
  import nib4_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cell_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)                                 cell_q[g] <= '0;
      else if (we && (waddr == AW'(g)))        cell_q[g] <= wdata;
    end
  end

  assign ra_data = cell_q[ra_addr];
  assign rb_data = cell_q[rb_addr];
  assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/nib4_alu.sv
module nib4_alu
  import nib4_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  opcode_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   lo,
  output logic [DW-1:0]   hi,
  output logic [FLAG_N-1:0] flags
);
  localparam int PW = 2 * DW;
  logic [PW-1:0] wide;

  always_comb begin
    case (op)
      OP_ADD:  wide = PW'(a) + PW'(b);
      OP_SUB:  wide = PW'(a) - PW'(b);
      OP_MUL:  wide = PW'(a) * PW'(b);
      OP_BOR:  wide = PW'(a | b);
      OP_BAND: wide = PW'(a & b);
      OP_BXOR: wide = PW'(a ^ b);
      OP_BNOT: wide = PW'(~a);
      default: wide = '0;
    endcase
    lo = wide[DW-1:0];
    hi = wide[PW-1:DW];
    flags            = '0;
    flags[FLAG_GT]   = a > b;
    flags[FLAG_LT]   = a < b;
    flags[FLAG_EQ]   = a == b;
    flags[FLAG_ZERO] = lo == '0;
  end
endmodule

// File: rtl/nib4_core.sv
module nib4_core
  import nib4_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int RAW = REG_AW,
  parameter int PW  = PC_W,
  parameter int IW  = WORD_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rom_we,
  input  logic [PW-1:0]  rom_addr,
  input  logic [IW-1:0]  rom_data,
  output logic           halted,
  input  logic [RAW-1:0] dbg_addr,
  output logic [DW-1:0]  dbg_data
);
  logic [PW-1:0]     pc_q, pc_n;
  logic [DW-1:0]     pbus_q, pbus_n, sbus_q, sbus_n, ebus_q, ebus_n;
  logic [FLAG_N-1:0] flags_q, flags_n;
  logic              halted_q, halt_n;
  logic [IW-1:0]     word;

  // decoded fields
  opcode_e           op;
  logic [RAW-1:0]    arg1, arg2;
  logic [DW-1:0]     imm;
  logic [PW-1:0]     tgt;
  logic [1:0]        csel, wsel;
  logic              rsel;

  // named events for checking
  logic              exec_en, alu_fire, branch_taken, wr_en;
  logic [DW-1:0]     opa, opb, alu_lo, alu_hi, wr_data;
  logic [FLAG_N-1:0] alu_flags;

  nib4_rom #(.AW(PW), .W(IW)) rom_i (
    .clk(clk), .we(rom_we), .waddr(rom_addr), .wdata(rom_data),
    .raddr(pc_q), .rdata(word)
  );

  assign op   = opcode_e'(word[15:12]);
  assign arg1 = word[11:8];
  assign arg2 = word[7:4];
  assign imm  = word[3:0];
  assign tgt  = word[11:7];
  assign csel = word[6:5];
  assign wsel = word[5:4];
  assign rsel = word[4];

  assign exec_en  = !halted_q;
  assign alu_fire = exec_en && is_alu_op(op);

  nib4_regfile #(.DW(DW), .AW(RAW)) rf_i (
    .clk(clk), .rst(rst), .we(wr_en && exec_en), .waddr(arg1), .wdata(wr_data),
    .ra_addr(arg1), .ra_data(opa), .rb_addr(arg2), .rb_data(opb),
    .rd_addr(dbg_addr), .rd_data(dbg_data)
  );

  nib4_alu #(.DW(DW)) alu_i (
    .op(op), .a(opa), .b(opb), .lo(alu_lo), .hi(alu_hi), .flags(alu_flags)
  );

  always_comb begin
    pc_n         = pc_q + 1'b1;
    pbus_n       = pbus_q;
    sbus_n       = sbus_q;
    ebus_n       = ebus_q;
    flags_n      = flags_q;
    halt_n       = halted_q;
    wr_en        = 1'b0;
    wr_data      = pbus_q;
    branch_taken = 1'b0;
    case (op)
      OP_READ: begin
        if (rsel) sbus_n = opa;
        else      pbus_n = opa;
      end
      OP_WRITE: begin
        wr_en = 1'b1;
        case (wsel)
          2'b00:   wr_data = pbus_q;
          2'b01:   wr_data = sbus_q;
          2'b10:   wr_data = ebus_q;
          default: wr_data = imm;
        endcase
      end
      OP_ADD, OP_SUB, OP_MUL, OP_BOR, OP_BAND, OP_BXOR, OP_BNOT: begin
        pbus_n  = alu_lo;
        flags_n = alu_flags;
        if (op == OP_MUL) ebus_n = alu_hi;
      end
      OP_JMP:    branch_taken = 1'b1;
      OP_JMPIF:  branch_taken = flags_q[csel];
      OP_JMPIFN: branch_taken = !flags_q[csel];
      OP_SWAP: begin
        pbus_n = sbus_q;
        sbus_n = pbus_q;
      end
      OP_HALT: begin
        halt_n = 1'b1;
        pc_n   = pc_q;
      end
      default: ;
    endcase
    if (branch_taken) pc_n = tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      pbus_q   <= '0;
      sbus_q   <= '0;
      ebus_q   <= '0;
      flags_q  <= '0;
      halted_q <= 1'b0;
    end else if (exec_en) begin
      pc_q     <= pc_n;
      pbus_q   <= pbus_n;
      sbus_q   <= sbus_n;
      ebus_q   <= ebus_n;
      flags_q  <= flags_n;
      halted_q <= halt_n;
    end
  end

  assign halted = halted_q;
endmodule

// File: rtl/nib4_core_chk.sv
module nib4_core_chk
  import nib4_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic [PC_W-1:0]   pc,
  input opcode_e           op,
  input logic [PC_W-1:0]   tgt,
  input logic              exec_en,
  input logic [DATA_W-1:0] pbus,
  input logic [DATA_W-1:0] sbus,
  input logic [DATA_W-1:0] ebus,
  input logic [FLAG_N-1:0] flags,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!halted && pc == '0 && flags == '0)) // R1
    else $error("reset state wrong");
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted) // R9
    else $error("halted dropped");
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
      halted |=> ($stable(pc) && $stable(pbus) && $stable(sbus) && $stable(ebus) && $stable(flags))) // R9
    else $error("state moved while halted");
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (exec_en && !is_pc_redirect(op)) |=> pc == PC_W'($past(pc) + 1'b1)) // R10
    else $error("pc did not step");
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op == OP_JMP) |=> pc == $past(tgt)) // R7
    else $error("jump target wrong");
  AST_SWAP_XCHG: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op == OP_SWAP) |=> (pbus == $past(sbus) && sbus == $past(pbus))) // R8
    else $error("swap wrong");
  AST_MUL_SPLIT: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op == OP_MUL) |=> ({ebus, pbus} == ({4'b0, $past(opa)} * {4'b0, $past(opb)}))) // R5
    else $error("product split wrong");
  AST_FLAG_EQ: assert property (@(posedge clk) disable iff (rst)
      (exec_en && is_alu_op(op)) |=> flags[FLAG_EQ] == ($past(opa) == $past(opb))) // R6
    else $error("equal flag wrong");
endmodule

bind nib4_core nib4_core_chk chk_i (
  .clk(clk), .rst(rst), .halted(halted_q), .pc(pc_q), .op(op), .tgt(tgt),
  .exec_en(exec_en), .pbus(pbus_q), .sbus(sbus_q), .ebus(ebus_q),
  .flags(flags_q), .opa(opa), .opb(opb)
);

// File: tb/nib4_core_tb_top.sv
module nib4_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rom_we = 1'b0;
  logic [4:0]  rom_addr = '0;
  logic [15:0] rom_data = '0;
  logic        halted;
  logic [3:0]  dbg_addr = '0;
  logic [3:0]  dbg_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] prog [32];

  // opcode, arg1, arg2 of each operation vector
  localparam logic [11:0] VECS [12] = '{
    12'h375, 12'h398, 12'h435, 12'h466, 12'h5FF, 12'h534,
    12'h509, 12'h65A, 12'h7C3, 12'h8F5, 12'h966, 12'h9F2
  };

  nib4_core dut_i (
    .clk(clk), .rst(rst), .rom_we(rom_we), .rom_addr(rom_addr), .rom_data(rom_data),
    .halted(halted), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [15:0] enc(input logic [3:0] o, input logic [3:0] a1,
                                      input logic [3:0] a2, input logic [3:0] im);
    return {o, a1, a2, im};
  endfunction

  function automatic logic [15:0] encj(input logic [3:0] o, input logic [4:0] t,
                                       input logic [1:0] s);
    return {o, t, s, 5'b0};
  endfunction

  // bench model: {flags[3:0] zero,eq,lt,gt ; hi ; lo}
  function automatic logic [11:0] model(input logic [3:0] o, input int a, input int b);
    int full;
    int lo;
    int hi;
    logic [3:0] f;
    case (o)
      4'h3: full = a + b;
      4'h4: full = a - b + 16;
      4'h5: full = a * b;
      4'h6: full = a | b;
      4'h7: full = a & b;
      4'h8: full = a ^ b;
      default: full = 15 - a;
    endcase
    lo = full % 16;
    hi = (o == 4'h5) ? full / 16 : 0;
    f = {lo == 0, a == b, a < b, a > b};
    return {f, 4'(hi), 4'(lo)};
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] v);
    dbg_addr = a;
    #1;
    v = dbg_data;
  endtask

  task automatic fill_halt();
    for (int i = 0; i < 32; i++) prog[i] = 16'hE000;
  endtask

  task automatic load_and_run(input int limit);
    rst = 1'b1;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      rom_we = 1'b1; rom_addr = 5'(i); rom_data = prog[i];
    end
    @(negedge clk);
    rom_we = 1'b0;
    rst = 1'b0;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (halted) break;
    end
    check("R9 halted after program", {3'b0, halted}, 4'h1);
  endtask

  initial begin
    logic [3:0] v;
    logic [11:0] e;
    logic [3:0] o, a, b;

    // operation vectors: R4 R5 R6 R3 R7 R11
    foreach (VECS[k]) begin
      o = VECS[k][11:8]; a = VECS[k][7:4]; b = VECS[k][3:0];
      e = model(o, int'(a), int'(b));
      fill_halt();
      prog[0]  = enc(4'h2, 4'd1, 4'h3, a);
      prog[1]  = enc(4'h2, 4'd2, 4'h3, b);
      prog[2]  = enc(o, 4'd1, 4'd2, 4'h0);
      prog[3]  = enc(4'h2, 4'd3, 4'h0, 4'h0);
      prog[4]  = enc(4'h2, 4'd4, 4'h2, 4'h0);
      prog[5]  = encj(4'hC, 5'd7, 2'd0);
      prog[6]  = enc(4'h2, 4'd5, 4'h3, 4'h1);
      prog[7]  = encj(4'hC, 5'd9, 2'd1);
      prog[8]  = enc(4'h2, 4'd6, 4'h3, 4'h1);
      prog[9]  = encj(4'hC, 5'd11, 2'd2);
      prog[10] = enc(4'h2, 4'd7, 4'h3, 4'h1);
      prog[11] = encj(4'hC, 5'd13, 2'd3);
      prog[12] = enc(4'h2, 4'd8, 4'h3, 4'h1);
      load_and_run(100);
      rd(4'd3, v); check($sformatf("R4 primary result vec %0d", k), v, e[3:0]);
      rd(4'd4, v); check($sformatf("R5 excess result vec %0d", k), v, e[7:4]);
      rd(4'd5, v); check($sformatf("R6 gt flag vec %0d", k), v, {3'b0, e[8]});
      rd(4'd6, v); check($sformatf("R6 lt flag vec %0d", k), v, {3'b0, e[9]});
      rd(4'd7, v); check($sformatf("R7 eq flag via JMPIFNOT vec %0d", k), v, {3'b0, e[10]});
      rd(4'd8, v); check($sformatf("R6 zero flag vec %0d", k), v, {3'b0, e[11]});
    end

    // READ select and SWAPBUS: R2 R8 R3
    fill_halt();
    prog[0] = enc(4'h2, 4'd1, 4'h3, 4'h5);
    prog[1] = enc(4'h2, 4'd2, 4'h3, 4'h9);
    prog[2] = enc(4'h1, 4'd1, 4'h0, 4'h0);
    prog[3] = enc(4'h1, 4'd2, 4'h1, 4'h0);
    prog[4] = enc(4'h2, 4'd5, 4'h0, 4'h0);
    prog[5] = enc(4'h2, 4'd6, 4'h1, 4'h0);
    prog[6] = enc(4'h0, 4'd0, 4'h0, 4'h0);
    prog[7] = enc(4'hD, 4'd0, 4'h0, 4'h0);
    prog[8] = enc(4'h2, 4'd3, 4'h0, 4'h0);
    prog[9] = enc(4'h2, 4'd4, 4'h1, 4'h0);
    load_and_run(100);
    rd(4'd5, v); check("R2 READ to primary", v, 4'h5);
    rd(4'd6, v); check("R2 READ to secondary", v, 4'h9);
    rd(4'd3, v); check("R8 primary after swap", v, 4'h9);
    rd(4'd4, v); check("R8 secondary after swap", v, 4'h5);

    // reset clears: R1
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 halted low in reset", {3'b0, halted}, 4'h0);
    for (int r = 0; r < 16; r++) begin
      rd(4'(r), v); check($sformatf("R1 register %0d cleared", r), v, 4'h0);
    end

    // HALT holds: R9
    fill_halt();
    prog[0] = enc(4'h2, 4'd1, 4'h3, 4'h6);
    prog[1] = enc(4'hE, 4'd0, 4'h0, 4'h0);
    prog[2] = enc(4'h2, 4'd1, 4'h3, 4'hF);
    prog[3] = encj(4'hA, 5'd2, 2'd0);
    load_and_run(100);
    repeat (20) @(negedge clk);
    check("R9 still halted", {3'b0, halted}, 4'h1);
    rd(4'd1, v); check("R9 register frozen after halt", v, 4'h6);

    // PC wrap, JMP, JMPIF taken, opcode F inert: R10 R7
    fill_halt();
    prog[0]  = encj(4'hB, 5'd5, 2'd2);
    prog[1]  = encj(4'hA, 5'd30, 2'd0);
    prog[5]  = enc(4'h2, 4'd11, 4'h3, 4'h7);
    prog[6]  = enc(4'h2, 4'd12, 4'h0, 4'h0);
    prog[30] = enc(4'h3, 4'd0, 4'd0, 4'h0);
    prog[31] = enc(4'hF, 4'd12, 4'h3, 4'hA);
    load_and_run(100);
    rd(4'd11, v); check("R10 wrap 31 to 0 then R7 JMPIF taken", v, 4'h7);
    rd(4'd12, v); check("R10 opcode F left register and bus untouched", v, 4'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule